// File: doc/BRIEF.md
# Filler-Cell Header Screen

This block watches the five header bytes of every cell that arrives on a byte-wide receive stream: four header octets followed by the header check byte. It decides whether the cell is an idle or an unassigned filler cell. It then tells the reassembly stage behind it whether to accept the cell or drop it. Filler cells are normally discarded here, so the downstream stage never sees them.

The header check value is recomputed from the received octets. It is compared against the received check byte either completely or only on the bit positions that cannot depend on the variable part of the header. A filler-looking cell whose check byte fails that comparison is kept, so that the downstream stage sees and handles the header error. Three static configuration inputs control the screen:
- accept every cell;
- ignore the check byte on filler cells;
- leave the four flow-control bits out of the filler match.

Top module: `fill_cell_screen`

## Requirements
- R1: A cell is classed idle when its 32-bit header (first octet in bits 31..24) equals 0x00000001; `dec_idle` reports this.
- R2: A cell is classed unassigned when header bits 31..4 are all zero and bit 0 is zero (bits 3..1 free); `dec_unassigned` reports this, and idle and unassigned are never both set.
- R3: With `cfg_pass_fill` = 1, every completed cell is forwarded (`dec_forward` = 1) whatever its class or check byte.
- R4: With `cfg_pass_fill` = 0 and `cfg_skip_hec` = 0, an idle cell is dropped only if all eight bits of the received check byte equal the computed value; otherwise it is forwarded.
- R5: With `cfg_pass_fill` = 0 and `cfg_skip_hec` = 0, an unassigned cell is dropped when check-byte bits 7, 6 and 0 equal the computed value; a mismatch on those bits forwards it, and a mismatch on bits 5..1 alone still drops it.
- R6: With `cfg_pass_fill` = 0 and `cfg_skip_hec` = 1, idle and unassigned cells are dropped on header match alone, whatever the check byte.
- R7: With `cfg_mask_gfc` = 1, header bits 31..28 are left out of the idle and unassigned match; with 0 they must be zero.
- R8: A cell that is neither idle nor unassigned is always forwarded.
- R9: The check value is CRC-8 with generator x^8+x^2+x+1, starting at zero, over the four header octets MSB first, then XORed with 0x55. The decision appears as a one-cycle `dec_valid` pulse in the cycle after the check byte is accepted. The configuration is sampled with the check byte, and the other outputs are zero whenever `dec_valid` is zero.
- R10: A byte with `in_sof` = 1 always starts a new cell, abandoning any partial one. Bytes with `in_valid` = 1 and `in_sof` = 0 outside a cell are ignored.
- R11: Synchronous reset clears all outputs and abandons any partial cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pass_fill | input | 1 | Forward every cell, filler or not |
| cfg_skip_hec | input | 1 | Drop filler cells without checking the check byte |
| cfg_mask_gfc | input | 1 | Leave header bits 31..28 out of the filler match |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the first header octet of a cell |
| in_data | input | 8 | Header octet or check byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_forward | output | 1 | 1 = pass the cell downstream, 0 = drop it |
| dec_idle | output | 1 | Cell was classed idle |
| dec_unassigned | output | 1 | Cell was classed unassigned |

## Verification
The decision pulse for one cell and the first header octet of the next cell can fall in the same cycle. This happens whenever cells arrive back to back. A stale header register or running CRC would then corrupt either the pending decision or the new cell. The bench sends runs of cells with no gap between them, in mixed classes and configurations. Its behavioural model predicts every output on every clock, so both the decision pulse in that cycle and the later decision of the following cell are judged.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int unsigned OCTET_W = 8;
  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;
  // Check-byte bits that cannot depend on header bits 3..1.
  localparam logic [7:0] HEC_FIXED_BITS = 8'hC1;

  // One octet through the CRC-8 register, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c;
  endfunction

  // Compare a received check byte with the computed one under a bit mask.
  function automatic logic hec_match(input logic [7:0] calc, input logic [7:0] rx,
                                     input logic [7:0] care);
    return ((calc ^ rx) & care) == 8'h00;
  endfunction

endpackage

// File: rtl/fcs_hdr_collect.sv
module fcs_hdr_collect
  import fcs_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic [OCTET_W-1:0]           in_data,
  output logic [HDR_BYTES*OCTET_W-1:0] hdr_word,
  output logic [7:0]                   crc_acc,
  output logic                         hec_strobe
);
  localparam int unsigned HW    = HDR_BYTES * OCTET_W;
  localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HDR_BYTES);

  logic [CNT_W-1:0] cnt;
  logic             collecting;
  logic             take_hdr;

  assign collecting = (cnt != '0) && (cnt != CNT_FULL);
  assign take_hdr   = in_valid && !in_sof && collecting;
  assign hec_strobe = in_valid && !in_sof && (cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      hdr_word <= '0;
      crc_acc  <= '0;
    end else if (in_valid && in_sof) begin
      cnt      <= CNT_W'(1);
      hdr_word <= {{(HW-OCTET_W){1'b0}}, in_data};
      crc_acc  <= crc8_step(8'h00, in_data);
    end else if (take_hdr) begin
      cnt      <= cnt + CNT_W'(1);
      hdr_word <= {hdr_word[HW-OCTET_W-1:0], in_data};
      crc_acc  <= crc8_step(crc_acc, in_data);
    end else if (hec_strobe) begin
      cnt      <= '0;
    end
  end

endmodule

// File: rtl/fcs_classify.sv
module fcs_classify
  import fcs_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 4,
  parameter int unsigned GFC_BITS  = 4
) (
  input  logic [HDR_BYTES*OCTET_W-1:0] hdr_word,
  input  logic [7:0]                   crc_acc,
  input  logic [7:0]                   hec_rx,
  input  logic                         cfg_mask_gfc,
  output logic                         cls_idle,
  output logic                         cls_unasg,
  output logic                         hec_full_ok,
  output logic                         hec_part_ok
);
  localparam int unsigned HW = HDR_BYTES * OCTET_W;
  localparam logic [HW-1:0] KEEP_MASK = {{GFC_BITS{1'b0}}, {(HW-GFC_BITS){1'b1}}};
  localparam logic [HW-1:0] IDLE_WORD = HW'(1);

  logic [HW-1:0] sel_hdr;
  logic [7:0]    hec_calc;

  assign sel_hdr  = cfg_mask_gfc ? (hdr_word & KEEP_MASK) : hdr_word;
  assign hec_calc = crc_acc ^ HEC_COSET;

  assign cls_idle    = (sel_hdr == IDLE_WORD);
  assign cls_unasg   = (sel_hdr[HW-1:4] == '0) && !sel_hdr[0];
  assign hec_full_ok = hec_match(hec_calc, hec_rx, 8'hFF);
  assign hec_part_ok = hec_match(hec_calc, hec_rx, HEC_FIXED_BITS);

endmodule

// File: rtl/fcs_decide.sv
module fcs_decide (
  input  logic clk,
  input  logic rst,
  input  logic hec_strobe,
  input  logic cls_idle,
  input  logic cls_unasg,
  input  logic hec_full_ok,
  input  logic hec_part_ok,
  input  logic cfg_pass_fill,
  input  logic cfg_skip_hec,
  output logic dec_valid,
  output logic dec_forward,
  output logic dec_idle,
  output logic dec_unassigned
);
  logic is_fill;
  logic hec_clean;
  logic drop_cell;

  assign is_fill   = cls_idle || cls_unasg;
  assign hec_clean = cls_idle ? hec_full_ok : hec_part_ok;
  assign drop_cell = !cfg_pass_fill && is_fill && (cfg_skip_hec || hec_clean);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid      <= 1'b0;
      dec_forward    <= 1'b0;
      dec_idle       <= 1'b0;
      dec_unassigned <= 1'b0;
    end else begin
      dec_valid      <= hec_strobe;
      dec_forward    <= hec_strobe && !drop_cell;
      dec_idle       <= hec_strobe && cls_idle;
      dec_unassigned <= hec_strobe && cls_unasg;
    end
  end

endmodule

// File: rtl/fill_cell_screen.sv
module fill_cell_screen
  import fcs_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 4,
  parameter int unsigned GFC_BITS  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_pass_fill,
  input  logic       cfg_skip_hec,
  input  logic       cfg_mask_gfc,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  output logic       dec_valid,
  output logic       dec_forward,
  output logic       dec_idle,
  output logic       dec_unassigned
);
  localparam int unsigned HW = HDR_BYTES * OCTET_W;

  logic [HW-1:0] hdr_word;
  logic [7:0]    crc_acc;
  logic          hec_strobe;
  logic          cls_idle;
  logic          cls_unasg;
  logic          hec_full_ok;
  logic          hec_part_ok;

  fcs_hdr_collect #(.HDR_BYTES(HDR_BYTES)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_data   (in_data),
    .hdr_word  (hdr_word),
    .crc_acc   (crc_acc),
    .hec_strobe(hec_strobe)
  );

  fcs_classify #(.HDR_BYTES(HDR_BYTES), .GFC_BITS(GFC_BITS)) u_classify (
    .hdr_word    (hdr_word),
    .crc_acc     (crc_acc),
    .hec_rx      (in_data),
    .cfg_mask_gfc(cfg_mask_gfc),
    .cls_idle    (cls_idle),
    .cls_unasg   (cls_unasg),
    .hec_full_ok (hec_full_ok),
    .hec_part_ok (hec_part_ok)
  );

  fcs_decide u_decide (
    .clk           (clk),
    .rst           (rst),
    .hec_strobe    (hec_strobe),
    .cls_idle      (cls_idle),
    .cls_unasg     (cls_unasg),
    .hec_full_ok   (hec_full_ok),
    .hec_part_ok   (hec_part_ok),
    .cfg_pass_fill (cfg_pass_fill),
    .cfg_skip_hec  (cfg_skip_hec),
    .dec_valid     (dec_valid),
    .dec_forward   (dec_forward),
    .dec_idle      (dec_idle),
    .dec_unassigned(dec_unassigned)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic clk,
  input logic rst,
  input logic cfg_pass_fill,
  input logic cfg_skip_hec,
  input logic hec_strobe,
  input logic cls_idle,
  input logic cls_unasg,
  input logic hec_full_ok,
  input logic hec_part_ok,
  input logic dec_valid,
  input logic dec_forward,
  input logic dec_idle,
  input logic dec_unassigned
);

  a_r2_class_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dec_idle && dec_unassigned));

  a_r9_pulse_follows_hec: assert property (@(posedge clk) disable iff (rst)
    hec_strobe |=> dec_valid);

  a_r9_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    !hec_strobe |=> !dec_valid && !dec_forward && !dec_idle && !dec_unassigned);

  a_r3_pass_all: assert property (@(posedge clk) disable iff (rst)
    hec_strobe && cfg_pass_fill |=> dec_forward);

  a_r8_nonfill_forward: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_idle && !dec_unassigned |-> dec_forward);

  a_r4_idle_full_check: assert property (@(posedge clk) disable iff (rst)
    hec_strobe && !cfg_pass_fill && !cfg_skip_hec && cls_idle
      |=> dec_forward != $past(hec_full_ok));

  a_r5_unasg_part_check: assert property (@(posedge clk) disable iff (rst)
    hec_strobe && !cfg_pass_fill && !cfg_skip_hec && cls_unasg
      |=> dec_forward != $past(hec_part_ok));

  a_r6_skip_drops_fill: assert property (@(posedge clk) disable iff (rst)
    hec_strobe && !cfg_pass_fill && cfg_skip_hec && (cls_idle || cls_unasg)
      |=> !dec_forward);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> !dec_valid && !dec_forward && !dec_idle && !dec_unassigned);

endmodule

bind fill_cell_screen fcs_checker u_fcs_checker (
  .clk           (clk),
  .rst           (rst),
  .cfg_pass_fill (cfg_pass_fill),
  .cfg_skip_hec  (cfg_skip_hec),
  .hec_strobe    (hec_strobe),
  .cls_idle      (cls_idle),
  .cls_unasg     (cls_unasg),
  .hec_full_ok   (hec_full_ok),
  .hec_part_ok   (hec_part_ok),
  .dec_valid     (dec_valid),
  .dec_forward   (dec_forward),
  .dec_idle      (dec_idle),
  .dec_unassigned(dec_unassigned)
);

// File: tb/tb_fill_cell_screen.sv
module tb_fill_cell_screen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_pass_fill = 1'b0;
  logic       cfg_skip_hec = 1'b0;
  logic       cfg_mask_gfc = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       dec_valid, dec_forward, dec_idle, dec_unassigned;

  int checks = 0;
  int fails  = 0;
  string tag = "R11 reset";

  // model expectations for the next falling edge
  bit e_v = 0, e_f = 0, e_i = 0, e_u = 0;
  byte unsigned cell_q[$];

  always #4 clk = ~clk;

  fill_cell_screen dut (
    .clk(clk), .rst(rst),
    .cfg_pass_fill(cfg_pass_fill), .cfg_skip_hec(cfg_skip_hec), .cfg_mask_gfc(cfg_mask_gfc),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .dec_valid(dec_valid), .dec_forward(dec_forward),
    .dec_idle(dec_idle), .dec_unassigned(dec_unassigned)
  );

  // Check value by long division of header*x^8 by the generator 0x107.
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r = r ^ (40'h107 << (i - 8));
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic judge_cell(input logic [2:0] cfg);
    logic [31:0] h, hm;
    logic [7:0]  rx, d;
    bit idle, unasg, fwd;
    h  = {cell_q[0], cell_q[1], cell_q[2], cell_q[3]};
    rx = cell_q[4];
    hm = cfg[0] ? {4'h0, h[27:0]} : h;
    idle  = (hm == 32'd1);
    unasg = (hm >> 4) == 0 && hm[0] == 1'b0;
    d = rx ^ ref_hec(h);
    if (cfg[2] || !(idle || unasg)) fwd = 1;
    else if (cfg[1]) fwd = 0;
    else if (idle) fwd = (d != 8'h00);
    else fwd = (d[7] | d[6] | d[0]);
    e_v = 1; e_f = fwd; e_i = idle; e_u = unasg;
  endtask

  task automatic compare();
    checks++;
    if ({dec_valid, dec_forward, dec_idle, dec_unassigned} !== {e_v, e_f, e_i, e_u}) begin
      fails++;
      $display("FAIL %s: v/f/i/u got %b%b%b%b exp %b%b%b%b", tag,
               dec_valid, dec_forward, dec_idle, dec_unassigned, e_v, e_f, e_i, e_u);
    end
  endtask

  // cfg = {pass_fill, skip_hec, mask_gfc}
  task automatic step(input bit v, input bit s, input logic [7:0] d,
                      input logic [2:0] cfg, input bit r);
    @(negedge clk);
    compare();
    {e_v, e_f, e_i, e_u} = 4'b0000;
    if (r) cell_q.delete();
    else if (v) begin
      if (s) begin cell_q.delete(); cell_q.push_back(d); end
      else if (cell_q.size() > 0) begin
        cell_q.push_back(d);
        if (cell_q.size() == 5) begin judge_cell(cfg); cell_q.delete(); end
      end
    end
    rst = r; in_valid = v; in_sof = s; in_data = d;
    {cfg_pass_fill, cfg_skip_hec, cfg_mask_gfc} = cfg;
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 8'h00, 3'b000, 0);
  endtask

  task automatic send_cell(input logic [31:0] h, input logic [7:0] hec, input logic [2:0] cfg);
    for (int k = 0; k < 4; k++) step(1, k == 0, h[31-8*k -: 8], cfg, 0);
    step(1, 0, hec, cfg, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    // R11: outputs cleared under reset
    step(0, 0, 8'h00, 3'b000, 1);
    step(0, 0, 8'h00, 3'b000, 1);
    step(0, 0, 8'h00, 3'b000, 0);

    tag = "R8 non-filler";
    send_cell(32'h0123_4567, ref_hec(32'h0123_4567), 3'b000);
    send_cell(32'h0000_0010, ref_hec(32'h0000_0010) ^ 8'h01, 3'b000);
    gap(2);

    tag = "R1 R4 idle full check";
    send_cell(32'h0000_0001, ref_hec(32'h0000_0001), 3'b000);
    gap(1);
    send_cell(32'h0000_0001, ref_hec(32'h0000_0001) ^ 8'h08, 3'b000);
    gap(1);

    tag = "R2 R5 unassigned partial check";
    send_cell(32'h0000_0000, ref_hec(32'h0000_0000), 3'b000);
    send_cell(32'h0000_000E, ref_hec(32'h0000_0000), 3'b000);
    send_cell(32'h0000_0004, ref_hec(32'h0000_0004) ^ 8'h80, 3'b000);
    send_cell(32'h0000_0002, ref_hec(32'h0000_0002) ^ 8'h01, 3'b000);
    send_cell(32'h0000_0006, ref_hec(32'h0000_0006) ^ 8'h3E, 3'b000);
    gap(1);

    tag = "R2 boundary headers";
    send_cell(32'h0000_0003, ref_hec(32'h0000_0003), 3'b000);
    send_cell(32'h0000_0011, ref_hec(32'h0000_0011), 3'b000);
    send_cell(32'h8000_0000, ref_hec(32'h8000_0000), 3'b000);
    gap(1);

    tag = "R3 pass all";
    send_cell(32'h0000_0001, ref_hec(32'h0000_0001), 3'b100);
    send_cell(32'h0000_0000, ref_hec(32'h0000_0000), 3'b110);
    gap(1);

    tag = "R6 skip check byte";
    send_cell(32'h0000_0001, 8'hA5, 3'b010);
    send_cell(32'h0000_0008, 8'hFF, 3'b010);
    send_cell(32'h0000_0100, 8'hFF, 3'b010);
    gap(1);

    tag = "R7 flow-control bits";
    send_cell(32'h5000_0001, ref_hec(32'h5000_0001), 3'b000);
    send_cell(32'h5000_0001, ref_hec(32'h5000_0001), 3'b001);
    send_cell(32'hF000_0002, ref_hec(32'hF000_0002), 3'b001);
    send_cell(32'h3000_0001, ref_hec(32'h3000_0001) ^ 8'h40, 3'b001);
    gap(1);

    tag = "R9 back-to-back cells";
    for (int n = 0; n < 12; n++) begin
      logic [31:0] h;
      h = (n % 3 == 0) ? 32'h0000_0001 : (n % 3 == 1) ? {28'h0, 4'(n * 2)} : 32'h0ABC_0000 + n;
      send_cell(h, ref_hec(h) ^ ((n % 4 == 3) ? 8'h02 : 8'h00), 3'(n % 8 < 6 ? 0 : n % 8));
    end
    gap(2);

    tag = "R10 restart and stray bytes";
    step(1, 1, 8'h00, 3'b000, 0);
    step(1, 0, 8'h00, 3'b000, 0);
    send_cell(32'h0000_0001, ref_hec(32'h0000_0001), 3'b000);
    step(1, 0, 8'h00, 3'b000, 0);
    step(1, 0, 8'h55, 3'b000, 0);
    step(1, 0, 8'h00, 3'b000, 0);
    gap(2);

    tag = "R11 reset mid-cell";
    step(1, 1, 8'h00, 3'b000, 0);
    step(1, 0, 8'h00, 3'b000, 0);
    step(1, 0, 8'h00, 3'b000, 0);
    step(0, 0, 8'h00, 3'b000, 1);
    step(1, 0, 8'h00, 3'b000, 0);
    step(1, 0, ref_hec(32'h0000_0000), 3'b000, 0);
    gap(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule